// File: doc/BRIEF.md
# Staggered SAR Conversion Sequencer

This block schedules a bank of successive-approximation converter sections that share one input clock. Every section repeats a frame of `SAR_BITS + 5` clocks (18 with the default 13-bit result). The frame has three calibration slots, one input-sample slot, one slot for each result bit, and a final transfer slot. There are as many sections as the frame has slots. A single phase counter drives all of them, and each section runs one clock behind its lower-numbered neighbour. As a result, exactly one section samples the analog input on every clock, and exactly one section hands over a finished result on every clock.

For each section the block drives one-hot slot strobes and a trial code for the DAC. The trial code is made of the bits decided so far plus the bit under test. The section's comparator bit is taken at the end of each trial clock and decides that bit. Finished results come out on a single result port, together with the index of the section that produced them. A separate timer holds a calibration-done flag low until a fixed number of clocks have elapsed since reset.

The frame slot of section k is `(phase - k) mod NSEC`. Slot numbers and their strobes are:

| Slot | Strobe |
|------|--------|
| 0 | `st_zero` |
| 1 | `st_azcmp` |
| 2 | `st_calcmp` |
| 3 | `st_samp` |
| 4 to `SAR_BITS+3` | `st_trial` |
| last | `st_xfer` |

Each section decodes its slot into a named slot kind: `SL_REFZ`, `SL_AZ`, `SL_CAL`, `SL_SAMP`, `SL_TRIAL` or `SL_XFER`. The calibration timer is a two-state machine:

| State | Meaning | Transition |
|-------|---------|------------|
| `CAL_RUN` | counting clocks since reset | goes to `CAL_DONE` on the clock where the count reaches `CAL_CYCLES-1` |
| `CAL_DONE` | calibration time has elapsed | left only through reset |

Top module: `ilv_sar_seq`

## Requirements
- R1: The slot of section k in the cycle that lies c clocks after reset release is `(c - k) mod 18`. The slot drives exactly one of that section's six strobes:
  - slot 0 drives `st_zero`
  - slot 1 drives `st_azcmp`
  - slot 2 drives `st_calcmp`
  - slot 3 drives `st_samp`
  - slots 4 to 16 drive `st_trial`
  - slot 17 drives `st_xfer`
- R2: On every cycle exactly one bit of `st_samp` is 1.
- R3: The trials run MSB first. In trial slot s, the bit under test is bit `16 - s` of the section's 13-bit `trial_code` field, and that bit reads 1. The bits above it hold the bits decided so far, and the bits below it read 0.
- R4: The tested bit is kept at 1 when the section's `cmp` bit is 1 at the end of the trial clock, and is cleared when it is 0. With a comparator that answers `trial_code <= target`, the final code equals `target`, including the targets 0 and 8191.
- R5: In the cycle that lies 14 clocks after a section's sample slot, all of the following hold:
  - `res_valid` is 1
  - `res_sec` gives that section's index
  - `res_code` gives its 13-bit result
- R6: `res_valid` stays 0 while the section in its transfer slot has not sampled since reset, so it first rises 14 cycles after reset release.
- R7: `cal_done` is 0 for the first `CAL_CYCLES` (10000) cycles after reset release. It then stays at 1 until the next reset.
- R8: A synchronous reset restarts the whole schedule, whether it arrives during conversion or later:
  - the phase counter returns to 0, so section 0 is in slot 0 on the first cycle
  - all result registers clear, so `res_code` reads 0 on that cycle
  - `cal_done` drops to 0 and the calibration count starts again

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all events advance on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp | input | NSEC | Comparator result of each section |
| st_zero | output | NSEC | Reference-zero sample strobe per section |
| st_azcmp | output | NSEC | Auto-zero compare strobe per section |
| st_calcmp | output | NSEC | Auto-calibrate compare strobe per section |
| st_samp | output | NSEC | Input-sample strobe per section |
| st_trial | output | NSEC | SAR bit-trial strobe per section |
| st_xfer | output | NSEC | Data-transfer strobe per section |
| trial_code | output | NSEC*SAR_BITS | Trial code per section; section k occupies bits `[k*SAR_BITS +: SAR_BITS]` |
| res_valid | output | 1 | A finished result is present on the result port |
| res_sec | output | $clog2(NSEC) | Index of the section delivering the result |
| res_code | output | SAR_BITS | Converted result |
| cal_done | output | 1 | Calibration time has elapsed since reset |

## Verification
The in-RTL assertions check the following on every cycle:
- the phase counter wraps cleanly
- each section raises exactly one strobe
- exactly one section samples
- the first trial after a sample tests only the MSB
- each trial decision follows the comparator
- a valid result always comes from the section in its transfer slot, with the index stepping by one
- `cal_done` never falls without reset

Some properties only the bench scenarios can show. These are the absolute slot of every section counted from reset release, and the 14-clock sample-to-result latency with the right code for extreme and patterned targets. They also include the exact cycle at which `cal_done` rises, and the complete restart after a mid-run reset.

// File: rtl/ilv_sar_pkg.sv
package ilv_sar_pkg;

    typedef enum logic [2:0] {
        SL_REFZ,
        SL_AZ,
        SL_CAL,
        SL_SAMP,
        SL_TRIAL,
        SL_XFER
    } slot_kind_t;

    typedef enum logic {
        CAL_RUN,
        CAL_DONE
    } cal_state_t;

    // Map a frame slot number to its kind for a given result width
    function automatic slot_kind_t slot_kind(input int s, input int nbits);
        if (s == 0)              return SL_REFZ;
        else if (s == 1)         return SL_AZ;
        else if (s == 2)         return SL_CAL;
        else if (s == 3)         return SL_SAMP;
        else if (s <= 3 + nbits) return SL_TRIAL;
        else                     return SL_XFER;
    endfunction

endpackage

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen #(
    parameter int NSEC = 18,
    localparam int SW = $clog2(NSEC)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (phase == SW'(NSEC - 1))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase == SW'(NSEC - 1)) |=> (phase == '0));

    a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase < SW'(NSEC));

endmodule

// File: rtl/ilv_cal_timer.sv
module ilv_cal_timer
    import ilv_sar_pkg::*;
#(
    parameter int CAL_CYCLES = 10000,
    localparam int CW = $clog2(CAL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic cal_done
);

    cal_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_RUN:  if (cnt_q == CW'(CAL_CYCLES - 1)) state_d = CAL_DONE;
            CAL_DONE: state_d = CAL_DONE;
        endcase
    end

    // State and count register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAL_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CAL_RUN)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CAL_RUN:  cal_done = 1'b0;
            CAL_DONE: cal_done = 1'b1;
        endcase
    end

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done);

    a_r7_no_early_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAL_RUN) |-> (cnt_q < CW'(CAL_CYCLES)));

endmodule

// File: rtl/ilv_sar_section.sv
module ilv_sar_section
    import ilv_sar_pkg::*;
#(
    parameter int SAR_BITS = 13,
    localparam int NSEC = SAR_BITS + 5,
    localparam int SW = $clog2(NSEC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SW-1:0]       slot,
    input  logic                cmp,
    output logic [5:0]          strobes,   // {xfer, trial, samp, cal, az, refz}
    output logic [SAR_BITS-1:0] trial_code,
    output logic [SAR_BITS-1:0] code,
    output logic                armed
);

    slot_kind_t kind;
    logic [SAR_BITS-1:0] mask;

    always_comb begin
        kind = slot_kind(int'(slot), SAR_BITS);
        mask = '0;
        if (kind == SL_TRIAL)
            mask = SAR_BITS'(1) << (SAR_BITS + 3 - int'(slot));
    end

    // Outputs by slot kind
    always_comb begin
        strobes    = '0;
        trial_code = code;
        unique case (kind)
            SL_REFZ:  strobes[0] = 1'b1;
            SL_AZ:    strobes[1] = 1'b1;
            SL_CAL:   strobes[2] = 1'b1;
            SL_SAMP:  strobes[3] = 1'b1;
            SL_TRIAL: begin
                strobes[4] = 1'b1;
                trial_code = code | mask;
            end
            SL_XFER:  strobes[5] = 1'b1;
        endcase
    end

    // Decided-bit register
    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            armed <= 1'b0;
        end else begin
            unique case (kind)
                SL_SAMP: begin
                    code  <= '0;
                    armed <= 1'b1;
                end
                SL_TRIAL: if (cmp) code <= code | mask;
                default: ;
            endcase
        end
    end

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot(strobes));

    a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
        strobes[3] |=> (trial_code == (SAR_BITS'(1) << (SAR_BITS - 1))));

    a_r4_decision: assert property (@(posedge clk) disable iff (rst)
        strobes[4] |=> (((code & $past(mask)) != '0) == $past(cmp)));

endmodule

// File: rtl/ilv_sar_seq.sv
module ilv_sar_seq
    import ilv_sar_pkg::*;
#(
    parameter int SAR_BITS   = 13,
    parameter int CAL_CYCLES = 10000,
    localparam int NSEC = SAR_BITS + 5,
    localparam int SW   = $clog2(NSEC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSEC-1:0]          cmp,
    output logic [NSEC-1:0]          st_zero,
    output logic [NSEC-1:0]          st_azcmp,
    output logic [NSEC-1:0]          st_calcmp,
    output logic [NSEC-1:0]          st_samp,
    output logic [NSEC-1:0]          st_trial,
    output logic [NSEC-1:0]          st_xfer,
    output logic [NSEC*SAR_BITS-1:0] trial_code,
    output logic                     res_valid,
    output logic [SW-1:0]            res_sec,
    output logic [SAR_BITS-1:0]      res_code,
    output logic                     cal_done
);

    logic [SW-1:0]       phase;
    logic [SAR_BITS-1:0] codes [NSEC];
    logic [NSEC-1:0]     armed;

    ilv_phase_gen #(.NSEC(NSEC)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    ilv_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
        .clk      (clk),
        .rst      (rst),
        .cal_done (cal_done)
    );

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        logic [SW:0]   wide;
        logic [SW-1:0] slot;
        logic [5:0]    stb;

        // Slot of this section: (phase - k) mod NSEC
        always_comb begin
            if ({1'b0, phase} >= (SW+1)'(k))
                wide = {1'b0, phase} - (SW+1)'(k);
            else
                wide = {1'b0, phase} + (SW+1)'(NSEC - k);
            slot = wide[SW-1:0];
        end

        ilv_sar_section #(.SAR_BITS(SAR_BITS)) u_sec (
            .clk        (clk),
            .rst        (rst),
            .slot       (slot),
            .cmp        (cmp[k]),
            .strobes    (stb),
            .trial_code (trial_code[k*SAR_BITS +: SAR_BITS]),
            .code       (codes[k]),
            .armed      (armed[k])
        );

        assign st_zero[k]   = stb[0];
        assign st_azcmp[k]  = stb[1];
        assign st_calcmp[k] = stb[2];
        assign st_samp[k]   = stb[3];
        assign st_trial[k]  = stb[4];
        assign st_xfer[k]   = stb[5];
    end

    // The section one step behind phase 0 of its frame is in transfer
    always_comb begin
        if (phase == SW'(NSEC - 1))
            res_sec = '0;
        else
            res_sec = phase + 1'b1;
        res_code  = codes[res_sec];
        res_valid = armed[res_sec];
    end

    a_r2_one_sample: assert property (@(posedge clk) disable iff (rst)
        $countones(st_samp) == 1);

    a_r5_from_xfer: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> st_xfer[res_sec]);

    a_r5_sec_steps: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_sec != SW'(NSEC - 1)) |=> (res_valid && res_sec == $past(res_sec) + 1'b1));

endmodule

// File: tb/ilv_sar_seq_test.sv
module ilv_sar_seq_test;

    localparam int SB   = 13;
    localparam int NSEC = SB + 5;
    localparam int SW   = $clog2(NSEC);
    localparam int CAL  = 10000;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NSEC-1:0]       cmp;
    logic [NSEC-1:0]       st_zero, st_azcmp, st_calcmp, st_samp, st_trial, st_xfer;
    logic [NSEC*SB-1:0]    trial_code;
    logic                  res_valid;
    logic [SW-1:0]         res_sec;
    logic [SB-1:0]         res_code;
    logic                  cal_done;

    int checks   = 0;
    int failures = 0;
    logic [SB-1:0] tgt [NSEC];
    bit            sampled [NSEC];

    always #4 clk = ~clk;

    ilv_sar_seq #(.SAR_BITS(SB), .CAL_CYCLES(CAL)) uut (
        .clk(clk), .rst(rst), .cmp(cmp),
        .st_zero(st_zero), .st_azcmp(st_azcmp), .st_calcmp(st_calcmp),
        .st_samp(st_samp), .st_trial(st_trial), .st_xfer(st_xfer),
        .trial_code(trial_code), .res_valid(res_valid), .res_sec(res_sec),
        .res_code(res_code), .cal_done(cal_done)
    );

    // Comparator model: DAC level not above the held target
    always_comb
        for (int k = 0; k < NSEC; k++)
            cmp[k] = (trial_code[k*SB +: SB] <= tgt[k]);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [SB-1:0] pick(input int k, input int c);
        case ((c / NSEC) % 6)
            0: return '0;
            1: return {SB{1'b1}};
            2: return SB'(13'h1555 ^ k);
            3: return SB'(13'h0AAA + k);
            4: return SB'((k * 455 + c * 7) % (1 << SB));
            default: return SB'(1) << (k % SB);
        endcase
    endfunction

    task automatic do_cycle(input int c, input bit first);
        for (int k = 0; k < NSEC; k++) begin
            int s = (c % NSEC + NSEC - k) % NSEC;
            logic [5:0] exp_stb, act_stb;
            exp_stb = '0;
            if (s == 0) exp_stb[0] = 1'b1;
            else if (s == 1) exp_stb[1] = 1'b1;
            else if (s == 2) exp_stb[2] = 1'b1;
            else if (s == 3) exp_stb[3] = 1'b1;
            else if (s <= SB + 3) exp_stb[4] = 1'b1;
            else exp_stb[5] = 1'b1;
            act_stb = {st_xfer[k], st_trial[k], st_samp[k], st_calcmp[k], st_azcmp[k], st_zero[k]};
            check(act_stb == exp_stb, "R1 strobes", int'(act_stb), int'(exp_stb));
            if (s >= 4 && s <= SB + 3 && sampled[k]) begin
                int b = SB + 3 - s;
                logic [SB-1:0] upper, exp_tc;
                upper  = ~((SB'(2) << b) - SB'(1));
                if (b == SB - 1) upper = '0;
                exp_tc = (tgt[k] & upper) | (SB'(1) << b);
                check(trial_code[k*SB +: SB] == exp_tc, "R3 trial code",
                      int'(trial_code[k*SB +: SB]), int'(exp_tc));
            end
        end
        check($countones(st_samp) == 1, "R2 single sampler", $countones(st_samp), 1);
        if (c >= SB + 1) begin
            int j = (c + 1) % NSEC;
            check(res_valid && res_sec == SW'(j), "R5 valid and index",
                  res_valid ? int'(res_sec) : -1, j);
            check(res_code == tgt[j], "R4 R5 result code", int'(res_code), int'(tgt[j]));
        end else begin
            check(!res_valid, "R6 no early result", int'(res_valid), 0);
        end
        check(cal_done == (c >= CAL), "R7 cal_done", int'(cal_done), int'(c >= CAL));
        if (first) begin
            check(st_zero[0], "R8 section 0 restarts in slot 0", int'(st_zero[0]), 1);
            check(res_code == '0, "R8 result cleared", int'(res_code), 0);
        end
        // Update targets for the section that samples this cycle
        for (int k = 0; k < NSEC; k++)
            if ((c % NSEC + NSEC - k) % NSEC == 3) begin
                tgt[k]     = pick(k, c);
                sampled[k] = 1'b1;
            end
    endtask

    task automatic session(input int n);
        for (int k = 0; k < NSEC; k++) begin
            sampled[k] = 1'b0;
            tgt[k]     = '0;
        end
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < n; c++) begin
            if (c > 0) @(negedge clk);
            do_cycle(c, c == 0);
        end
    endtask

    initial begin
        for (int k = 0; k < NSEC; k++) tgt[k] = '0;
        session(CAL + 120);   // R7 rise and long conversion run
        session(300);         // R8 restart after mid-run reset
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule